// File: doc/BRIEF.md
# Stepped SPI Serial Clock Generator

This block derives an SPI serial clock from the system clock and hands a shift engine two single-cycle strobes: one marking the edge on which outgoing data should be launched, one marking the edge on which incoming data should be captured. The divide ratio comes from a 5-bit prescale code with a two-segment, non-linear mapping. The low half of the code space divides by the code itself. The upper half divides by twice its lower four bits, which reaches ratios up to 30 in steps of two.

Clock polarity sets the idle level of the serial clock. Clock phase decides whether data is captured on the leading edge or the trailing edge of each period. A late-capture select moves the capture strobe to the opposite edge, for the fastest divide settings where the round trip through the pads eats into the setup window.

The configuration is sampled on every cycle in which the enable is low and is frozen while the enable is high. A transfer therefore always runs with the settings that were in place when it started. Odd ratios split each period unevenly: the half at the idle level is the longer one.

Top module: `spiclk_gen`

## Requirements
- R1: A prescale code c from 2 to 15 gives a serial clock period of c system clock cycles. Codes 0 and 1 give a period of 2 cycles.
- R2: A prescale code c from 16 to 31 gives a period of 2*(c-16) cycles. Code 16 gives a period of 2 cycles.
- R3: For a period of r cycles, each period has ceil(r/2) cycles at the idle level and then floor(r/2) cycles at the active level.
- R4: While the enable is low, the serial clock sits at the level of the polarity input, from one cycle after that input is set.
- R5: The first leading edge (idle to active level) appears at the ceil(r/2)-th rising system clock edge that samples the enable high.
- R6: The shift strobe is a one-cycle pulse in the cycle in which the serial clock changes. It follows the trailing edge when the phase input is 0 and the leading edge when it is 1.
- R7: The sample strobe is a one-cycle pulse that follows the edge opposite to the shift strobe. When late capture is 1, it moves to the other edge, so it coincides with the shift strobe.
- R8: Changes to the prescale, polarity, phase or late-capture inputs while the enable is high have no effect until the enable goes low.
- R9: After the enable is sampled low, the serial clock is back at the polarity level in the next cycle, and neither strobe pulses while the enable stays low.
- R10: After reset the serial clock is low and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_prescale | input | 5 | Divide code |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0: capture on the leading edge, 1: capture on the trailing edge |
| cfg_late_capture | input | 1 | Moves capture to the opposite edge |
| xfer_en | input | 1 | High for the duration of a transfer |
| sclk | output | 1 | Serial clock |
| shift_stb | output | 1 | Launch strobe for the shift engine |
| sample_stb | output | 1 | Capture strobe for the shift engine |

## Verification
The hardest condition to reach from the ports is a configuration change in the middle of an active transfer. Ordinary use never does this, yet it is the case where the frozen configuration must win over the live inputs. The bench starts a transfer with an odd ratio. Part way through an active half-period, it changes every configuration input at once. It then keeps comparing the waveform against the original settings for several more periods. After that it drops the enable and checks that the new polarity takes over at once. A sweep of all 32 codes under every combination of polarity, phase and late capture covers both halves of the code map and the uneven split of odd ratios.

// File: rtl/spiclk_pkg.sv
// Shared definitions for the stepped SPI clock generator.
// Assumes: mode bits are single flags; widths of the divider live in module parameters.
package spiclk_pkg;

    // Frozen per-transfer clocking mode
    typedef struct packed {
        logic cpol;
        logic cpha;
        logic late;
    } spiclk_mode_t;

    localparam int DEFAULT_CODE_W = 5;

endpackage

// File: rtl/spiclk_ratio_decode.sv
// Turns the non-linear prescale code into the two half-period lengths, minus one.
// Lower half of the code space divides by the code; upper half divides by twice
// the remaining bits. Results below 2 are raised to 2.
// Assumes: CNT_W = CODE_W-1 is enough for the longest half minus one.
module spiclk_ratio_decode #(
    parameter int CODE_W = 5,
    parameter int CNT_W  = CODE_W - 1
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  idle_len_m1,
    output logic [CNT_W-1:0]  act_len_m1
);
    localparam int EXT_W = CODE_W + 1;

    logic [CODE_W-1:0] ratio;
    logic [EXT_W-1:0]  ratio_ext;
    logic [EXT_W-1:0]  idle_len;
    logic [EXT_W-1:0]  act_len;
    logic [EXT_W-1:0]  idle_m1_ext;
    logic [EXT_W-1:0]  act_m1_ext;

    // Map the code to a divide ratio with the minimum clamp
    always_comb begin
        if (code[CODE_W-1]) begin
            ratio = {code[CODE_W-2:0], 1'b0};
        end else begin
            ratio = code;
        end
        if (ratio < CODE_W'(2)) begin
            ratio = CODE_W'(2);
        end
    end

    // Split the ratio: the idle-level half takes the extra cycle of odd ratios
    always_comb begin
        ratio_ext   = {1'b0, ratio};
        idle_len    = (ratio_ext + EXT_W'(1)) >> 1;
        act_len     = ratio_ext >> 1;
        idle_m1_ext = idle_len - EXT_W'(1);
        act_m1_ext  = act_len - EXT_W'(1);
        idle_len_m1 = idle_m1_ext[CNT_W-1:0];
        act_len_m1  = act_m1_ext[CNT_W-1:0];
    end

endmodule

// File: rtl/spiclk_half_timer.sv
// Counts half-periods and toggles the clock phase; emits registered pulses in
// the cycle where the phase goes active (leading) or back to idle (trailing).
// Assumes: the length inputs are stable while run is high.
module spiclk_half_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] idle_len_m1,
    input  logic [CNT_W-1:0] act_len_m1,
    output logic             active,
    output logic             lead_pulse,
    output logic             trail_pulse
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;

    // Half-period counter, phase flag and edge pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt         <= '0;
            active      <= 1'b0;
            lead_pulse  <= 1'b0;
            trail_pulse <= 1'b0;
        end else if (!run) begin
            cnt         <= idle_len_m1;
            active      <= 1'b0;
            lead_pulse  <= 1'b0;
            trail_pulse <= 1'b0;
        end else if (cnt == '0) begin
            active      <= !active;
            lead_pulse  <= !active;
            trail_pulse <= active;
            cnt         <= active ? idle_len_m1 : act_len_m1;
        end else begin
            cnt         <= cnt - CNT_W'(1);
            lead_pulse  <= 1'b0;
            trail_pulse <= 1'b0;
        end
    end

    // R6
    edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead_pulse && trail_pulse));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!active && !lead_pulse && !trail_pulse));

    // R1
    lead_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lead_pulse |=> !lead_pulse);

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt != CNT_MAX);

endmodule

// File: rtl/spiclk_strobe_map.sv
// Routes the leading/trailing edge pulses to launch and capture strobes
// according to phase and the late-capture select.
// Assumes: at most one of the two edge pulses is high in any cycle.
module spiclk_strobe_map (
    input  logic                    clk,
    input  logic                    rst_n,
    input  spiclk_pkg::spiclk_mode_t mode,
    input  logic                    lead_pulse,
    input  logic                    trail_pulse,
    output logic                    shift_stb,
    output logic                    sample_stb
);
    logic sample_on_lead;

    // Pick the edge for each strobe
    always_comb begin
        sample_on_lead = (!mode.cpha) ^ mode.late;
        shift_stb      = mode.cpha ? lead_pulse : trail_pulse;
        sample_stb     = sample_on_lead ? lead_pulse : trail_pulse;
    end

    // R7
    dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_stb && sample_stb) |-> mode.late);

endmodule

// File: rtl/spiclk_gen.sv
// Stepped SPI serial clock generator: freezes the configuration for the length
// of a transfer, decodes the prescale code, times half-periods and produces
// the serial clock plus launch/capture strobes.
// Assumes: configuration is set at least one cycle before the enable rises.
module spiclk_gen #(
    parameter int CODE_W = spiclk_pkg::DEFAULT_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] cfg_prescale,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_late_capture,
    input  logic              xfer_en,
    output logic              sclk,
    output logic              shift_stb,
    output logic              sample_stb
);
    import spiclk_pkg::*;

    localparam int CNT_W = CODE_W - 1;

    logic [CODE_W-1:0] code_q;
    spiclk_mode_t      mode_q;
    logic [CODE_W-1:0] code_eff;
    logic [CNT_W-1:0]  idle_len_m1;
    logic [CNT_W-1:0]  act_len_m1;
    logic              active;
    logic              lead_pulse;
    logic              trail_pulse;

    // Capture configuration while idle, hold it during a transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            mode_q <= '0;
        end else if (!xfer_en) begin
            code_q      <= cfg_prescale;
            mode_q.cpol <= cfg_cpol;
            mode_q.cpha <= cfg_cpha;
            mode_q.late <= cfg_late_capture;
        end
    end

    // Idle preload uses the live code, a running transfer the frozen one
    always_comb begin
        code_eff = xfer_en ? code_q : cfg_prescale;
    end

    spiclk_ratio_decode #(
        .CODE_W(CODE_W),
        .CNT_W (CNT_W)
    ) i_decode (
        .code       (code_eff),
        .idle_len_m1(idle_len_m1),
        .act_len_m1 (act_len_m1)
    );

    spiclk_half_timer #(
        .CNT_W(CNT_W)
    ) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (xfer_en),
        .idle_len_m1(idle_len_m1),
        .act_len_m1 (act_len_m1),
        .active     (active),
        .lead_pulse (lead_pulse),
        .trail_pulse(trail_pulse)
    );

    spiclk_strobe_map i_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode_q),
        .lead_pulse (lead_pulse),
        .trail_pulse(trail_pulse),
        .shift_stb  (shift_stb),
        .sample_stb (sample_stb)
    );

    // Serial clock: phase flag seen through the frozen polarity
    always_comb begin
        sclk = active ^ mode_q.cpol;
    end

    // R9
    strobe_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_stb || sample_stb) |-> $past(xfer_en));

    // R8
    frozen_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_en && $past(xfer_en)) |-> ($stable(code_q) && $stable(mode_q)));

endmodule

// File: tb/test_spiclk_gen.sv
`timescale 1ns/1ps
module test_spiclk_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] cfg_prescale = '0;
    logic       cfg_cpol = 1'b0;
    logic       cfg_cpha = 1'b0;
    logic       cfg_late_capture = 1'b0;
    logic       xfer_en = 1'b0;
    logic       sclk, shift_stb, sample_stb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    spiclk_gen i_spiclk_gen (
        .clk(clk), .rst_n(rst_n), .cfg_prescale(cfg_prescale),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_late_capture(cfg_late_capture), .xfer_en(xfer_en),
        .sclk(sclk), .shift_stb(shift_stb), .sample_stb(sample_stb)
    );

    function automatic int ratio_of(int code);
        int r;
        r = (code >= 16) ? 2 * (code - 16) : code;
        if (r < 2) r = 2;
        return r;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Compare outputs n cycles after enable rose, for the given frozen settings
    task automatic check_point(int n, int code, int cpol, int cpha, int late);
        int r, a, b, act_lvl, lead, trail, shf, smp;
        string req_clk;
        r = ratio_of(code);
        a = (r + 1) / 2;
        b = r / 2;
        act_lvl = (n >= a && ((n - a) % r) < b) ? 1 : 0;
        lead  = (n >= a && ((n - a) % r) == 0) ? 1 : 0;
        trail = (n >= r && (n % r) == 0) ? 1 : 0;
        shf = (cpha != 0) ? lead : trail;
        smp = (((cpha == 0) ? 1 : 0) ^ late) != 0 ? lead : trail;
        if (n < a)              req_clk = "R5";
        else if (r % 2 == 1)    req_clk = "R3";
        else if (code >= 16)    req_clk = "R2";
        else                    req_clk = "R1";
        check(req_clk, $sformatf("sclk code %0d n %0d", code, n), int'(sclk), act_lvl ^ cpol);
        check("R6", $sformatf("shift code %0d n %0d", code, n), int'(shift_stb), shf);
        check("R7", $sformatf("sample code %0d n %0d", code, n), int'(sample_stb), smp);
    endtask

    task automatic set_cfg(int code, int cpol, int cpha, int late);
        cfg_prescale     = 5'(code);
        cfg_cpol         = 1'(cpol);
        cfg_cpha         = 1'(cpha);
        cfg_late_capture = 1'(late);
    endtask

    task automatic check_idle(int cpol, int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            check("R9", "idle sclk", int'(sclk), cpol);
            check("R9", "idle shift", int'(shift_stb), 0);
            check("R9", "idle sample", int'(sample_stb), 0);
        end
    endtask

    task automatic run_pattern(int code, int cpol, int cpha, int late);
        int r, len;
        r = ratio_of(code);
        len = 2 * r + (r + 1) / 2 + 1;
        @(negedge clk);
        set_cfg(code, cpol, cpha, late);
        @(negedge clk);
        @(negedge clk);
        check("R4", "sclk idle before enable", int'(sclk), cpol);
        xfer_en = 1'b1;
        for (int n = 1; n <= len; n++) begin
            @(negedge clk);
            check_point(n, code, cpol, cpha, late);
        end
        xfer_en = 1'b0;
        check_idle(cpol, 2);
    endtask

    initial begin
        // R10: reset state
        set_cfg(3, 0, 0, 0);
        repeat (3) @(negedge clk);
        check("R10", "sclk in reset", int'(sclk), 0);
        check("R10", "shift in reset", int'(shift_stb), 0);
        check("R10", "sample in reset", int'(sample_stb), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", "sclk after reset", int'(sclk), 0);
        check("R10", "strobes after reset", int'(shift_stb | sample_stb), 0);

        // R4: polarity follows while idle, one cycle later
        cfg_cpol = 1'b1;
        @(negedge clk);
        check("R4", "idle sclk follows polarity high", int'(sclk), 1);
        cfg_cpol = 1'b0;
        @(negedge clk);
        check("R4", "idle sclk follows polarity low", int'(sclk), 0);

        // R1 R2 R3 R5 R6 R7: every code under every mode
        for (int code = 0; code < 32; code++) begin
            for (int m = 0; m < 8; m++) begin
                run_pattern(code, m & 1, (m >> 1) & 1, (m >> 2) & 1);
            end
        end

        // R8: change every setting mid-transfer, inside an active half
        @(negedge clk);
        set_cfg(7, 0, 1, 0);
        @(negedge clk);
        @(negedge clk);
        xfer_en = 1'b1;
        for (int n = 1; n <= 30; n++) begin
            @(negedge clk);
            check_point(n, 7, 0, 1, 0);
            if (n == 5) set_cfg(19, 1, 0, 1);
        end
        check("R8", "sclk still old polarity at end", int'(sclk), 0);
        // R9: drop enable; the new polarity is taken on at once
        xfer_en = 1'b0;
        check_idle(1, 4);

        // R8 follow-up: the new settings apply to the next transfer
        xfer_en = 1'b1;
        for (int n = 1; n <= 14; n++) begin
            @(negedge clk);
            check_point(n, 19, 1, 0, 1);
        end
        xfer_en = 1'b0;
        check_idle(1, 2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule